// File: doc/BRIEF.md
# Last Committed Value Table

This block is a small set-associative store that holds, for each static micro-op, the result its most recent committed instance produced. The fetch side presents a program-counter value and, one cycle later, gets back a hit flag and the stored 64-bit result. An equality predictor pairs that value with its own decision. A miss means no value is known, and the consumer must then treat the prediction as inequality and use nothing.

The commit side writes every retiring micro-op's result, whether the prediction for that micro-op was right or wrong. A write that finds its entry overwrites it in place. A write that misses allocates a way: the lowest-numbered invalid way first, and otherwise a way chosen by per-set pseudo-LRU bits. Only committed results are ever visible. No in-flight value is forwarded, including a write that lands in the same cycle as a read of the same entry.

Top module: `lcvt_table`

## Requirements
- R1: When reset is asserted, every entry becomes invalid, so every read after reset misses until a write installs its entry.
- R2: A read presented at a clock edge produces its result at the following edge. In any cycle that follows a cycle without a read, `rd_hit_o` is 0 and `rd_value_o` is 0.
- R3: After a write of value V for program counter P, a later read of P hits and returns V, unless a write to the same set has evicted the entry in between.
- R4: A read of a program counter that has no valid matching entry returns `rd_hit_o`=0 and `rd_value_o`=0.
- R5: A write whose set already holds a valid entry with the same tag replaces that entry's value in place. It allocates no second copy, and the other ways of the set keep their contents.
- R6: The set index is `pc[IDX_W-1:0]`. The tag is the XOR of consecutive 13-bit slices of `pc[PC_W-1:IDX_W]`, with slice 0 starting at bit IDX_W and the last slice zero-padded at the top. Two program counters with equal index and equal folded tag share one entry.
- R7: A write miss into a set that still has invalid ways fills the lowest-numbered invalid way.
- R8: Each set keeps one recently-used bit per way. A write marks its way. If that would mark every way, only the written way stays marked. On a write miss into a full set, the victim is the lowest-numbered unmarked way.
- R9: When a read and a write are presented in the same cycle, the read returns the contents held before that write (a miss if the entry was absent). A subsequent read sees the written value.
- R10: Reads do not change the replacement state. Only writes update the recently-used bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; invalidates all entries |
| rd_en_i | input | 1 | Fetch-side lookup request |
| rd_pc_i | input | PC_W | Program counter of the looked-up micro-op |
| rd_hit_o | output | 1 | Lookup result valid and matched, one cycle after the request |
| rd_value_o | output | VAL_W | Last committed value on a hit, zero otherwise |
| wr_en_i | input | 1 | Commit-side write request |
| wr_pc_i | input | PC_W | Program counter of the committed micro-op |
| wr_value_i | input | VAL_W | Committed result |

## Verification
A wrong valid bit or tag shows at the next read of that program counter: a false hit or a lost hit, one cycle after the read. A corrupt recently-used bit stays invisible until a write miss into that set chooses the wrong victim. It then appears as a miss on an entry that should have survived, or a hit on one that should have been evicted. The bench therefore fills sets to capacity and probes every resident program counter after each eviction. A broken fold hash shows up only when an aliasing program counter hits, or fails to hit, an entry installed under a different program counter.

// File: rtl/lcvt_pkg.sv
package lcvt_pkg;
  localparam int unsigned TAG_W_DEF = 13;
  localparam int unsigned VAL_W_DEF = 64;
endpackage

// File: rtl/lcvt_hash.sv
module lcvt_hash #(
  parameter int unsigned PC_W  = 64,
  parameter int unsigned IDX_W = 6,
  parameter int unsigned TAG_W = 13
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [TAG_W-1:0] tag_o
);
  localparam int unsigned UP_W   = PC_W - IDX_W;
  localparam int unsigned NSLICE = (UP_W + TAG_W - 1) / TAG_W;

  logic [NSLICE*TAG_W-1:0] padded;

  assign idx_o = pc_i[IDX_W-1:0];

  always_comb begin
    padded = '0;
    padded[UP_W-1:0] = pc_i[PC_W-1:IDX_W];
    tag_o = '0;
    for (int i = 0; i < NSLICE; i++) tag_o ^= padded[i*TAG_W +: TAG_W];
  end
endmodule

// File: rtl/lcvt_way_match.sv
module lcvt_way_match #(
  parameter int unsigned WAYS  = 3,
  parameter int unsigned TAG_W = 13
) (
  input  logic [WAYS-1:0]       valid_i,
  input  logic [WAYS*TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]      tag_i,
  output logic [WAYS-1:0]       match_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match_o[w] = valid_i[w] && (tags_i[w*TAG_W +: TAG_W] == tag_i);
  end
endmodule

// File: rtl/lcvt_victim.sv
module lcvt_victim #(
  parameter int unsigned WAYS  = 3,
  parameter int unsigned WAY_W = 2
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAYS-1:0]  used_i,
  output logic [WAY_W-1:0] way_o
);
  logic found;

  // first invalid way wins, else first way not recently used
  always_comb begin
    way_o = '0;
    found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !valid_i[w]) begin
        way_o = WAY_W'(w);
        found = 1'b1;
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (!found && !used_i[w]) begin
        way_o = WAY_W'(w);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcvt_table.sv
module lcvt_table
  import lcvt_pkg::*;
#(
  parameter int unsigned PC_W  = 64,
  parameter int unsigned SETS  = 64,
  parameter int unsigned WAYS  = 3,
  parameter int unsigned TAG_W = TAG_W_DEF,
  parameter int unsigned VAL_W = VAL_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [PC_W-1:0]  rd_pc_i,
  output logic             rd_hit_o,
  output logic [VAL_W-1:0] rd_value_o,
  input  logic             wr_en_i,
  input  logic [PC_W-1:0]  wr_pc_i,
  input  logic [VAL_W-1:0] wr_value_i
);
  localparam int unsigned IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [WAYS-1:0]  valid_q [SETS];
  logic [WAYS-1:0]  used_q  [SETS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [VAL_W-1:0] val_q   [SETS][WAYS];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;
  logic [WAYS*TAG_W-1:0] rd_tags, wr_tags;
  logic [WAYS-1:0]  rd_match, wr_match;

  lcvt_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_rd_hash (
    .pc_i(rd_pc_i), .idx_o(rd_idx), .tag_o(rd_tag));
  lcvt_hash #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_wr_hash (
    .pc_i(wr_pc_i), .idx_o(wr_idx), .tag_o(wr_tag));

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      rd_tags[w*TAG_W +: TAG_W] = tag_q[rd_idx][w];
      wr_tags[w*TAG_W +: TAG_W] = tag_q[wr_idx][w];
    end
  end

  lcvt_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_rd_match (
    .valid_i(valid_q[rd_idx]), .tags_i(rd_tags), .tag_i(rd_tag), .match_o(rd_match));
  lcvt_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_wr_match (
    .valid_i(valid_q[wr_idx]), .tags_i(wr_tags), .tag_i(wr_tag), .match_o(wr_match));

  // ---------------- read port ----------------
  logic [VAL_W-1:0] rd_sel;
  logic             rd_hit_q;
  logic [VAL_W-1:0] rd_val_q;

  always_comb begin
    rd_sel = '0;
    for (int w = 0; w < WAYS; w++)
      if (rd_match[w]) rd_sel |= val_q[rd_idx][w];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_hit_q <= 1'b0;
      rd_val_q <= '0;
    end else begin
      rd_hit_q <= rd_en_i && (|rd_match);
      rd_val_q <= rd_en_i ? rd_sel : '0;
    end
  end

  assign rd_hit_o   = rd_hit_q;
  assign rd_value_o = rd_val_q;

  // ---------------- write port ----------------
  logic             wr_hit;
  logic [WAY_W-1:0] hit_way, vic_way, wr_way;
  logic [WAYS-1:0]  wr_onehot, used_nxt;

  assign wr_hit = |wr_match;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++)
      if (wr_match[w]) hit_way = WAY_W'(w);
  end

  lcvt_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .valid_i(valid_q[wr_idx]), .used_i(used_q[wr_idx]), .way_o(vic_way));

  assign wr_way    = wr_hit ? hit_way : vic_way;
  assign wr_onehot = WAYS'(1) << wr_way;

  always_comb begin
    used_nxt = used_q[wr_idx] | wr_onehot;
    if (&used_nxt) used_nxt = wr_onehot;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        used_q[s]  <= '0;
      end
    end else if (wr_en_i) begin
      valid_q[wr_idx] <= valid_q[wr_idx] | wr_onehot;
      used_q[wr_idx]  <= used_nxt;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx][wr_way] <= wr_tag;
      val_q[wr_idx][wr_way] <= wr_value_i;
    end
  end

  // ---------------- assertions ----------------
  assert_single_copy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> $onehot0(wr_match));

  assert_fill_invalid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_hit && !(&valid_q[wr_idx])) |-> !valid_q[wr_idx][vic_way]);

  assert_idle_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> (!rd_hit_o && rd_value_o == '0));

  assert_write_visible_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i) && rd_en_i && rd_pc_i == $past(wr_pc_i))
      |=> (rd_hit_o && rd_value_o == $past(wr_value_i, 2)));

  if (WAYS > 1) begin : g_used_chk
    assert_used_not_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> !(&used_q[$past(wr_idx)]));
  end
endmodule

// File: tb/lcvt_table_tb.sv
`timescale 1ns/1ps
module lcvt_table_tb;
  localparam int PC_W = 64, SETS = 64, WAYS = 3, TAG_W = 13, VAL_W = 64;
  localparam int IDX_W = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rd_en_i = 1'b0, wr_en_i = 1'b0;
  logic [PC_W-1:0] rd_pc_i = '0, wr_pc_i = '0;
  logic [VAL_W-1:0] wr_value_i = '0;
  logic rd_hit_o;
  logic [VAL_W-1:0] rd_value_o;
  int total = 0, passed = 0;

  lcvt_table #(.PC_W(PC_W), .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .VAL_W(VAL_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .rd_pc_i(rd_pc_i),
    .rd_hit_o(rd_hit_o), .rd_value_o(rd_value_o), .wr_en_i(wr_en_i),
    .wr_pc_i(wr_pc_i), .wr_value_i(wr_value_i));

  always #4 clk_i = ~clk_i;

  function automatic logic [PC_W-1:0] mk(input logic [PC_W-IDX_W-1:0] up, input int idx);
    return {up, idx[IDX_W-1:0]};
  endfunction

  task automatic check(input string req, input logic hit, input logic [VAL_W-1:0] val,
                       input logic eh, input logic [VAL_W-1:0] ev);
    total++;
    if (hit === eh && val === ev) passed++;
    else $display("FAIL %s: hit=%0b value=%h expected hit=%0b value=%h", req, hit, val, eh, ev);
  endtask

  task automatic do_wr(input logic [PC_W-1:0] pc, input logic [VAL_W-1:0] v);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_pc_i = pc; wr_value_i = v;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic chk_rd(input string req, input logic [PC_W-1:0] pc,
                        input logic eh, input logic [VAL_W-1:0] ev);
    @(negedge clk_i);
    rd_en_i = 1'b1; rd_pc_i = pc;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    check(req, rd_hit_o, rd_value_o, eh, ev);
  endtask

  task automatic t_reset_R1;
    chk_rd("R1", mk(58'h5, 1), 1'b0, '0);
    do_wr(mk(58'h5, 1), 64'h1111);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    chk_rd("R1", mk(58'h5, 1), 1'b0, '0);
  endtask

  task automatic t_basic_R3_R4_R2;
    do_wr(mk(58'h7, 2), 64'hDEAD_BEEF_0123_4567);
    chk_rd("R3", mk(58'h7, 2), 1'b1, 64'hDEAD_BEEF_0123_4567);
    chk_rd("R4", mk(58'h8, 2), 1'b0, '0);
    chk_rd("R4", mk(58'h7, 9), 1'b0, '0);
    @(negedge clk_i);
    check("R2", rd_hit_o, rd_value_o, 1'b0, '0);
  endtask

  task automatic t_overwrite_R5;
    do_wr(mk(58'h10, 4), 64'hA);
    do_wr(mk(58'h11, 4), 64'hB);
    do_wr(mk(58'h10, 4), 64'hC);
    chk_rd("R5", mk(58'h10, 4), 1'b1, 64'hC);
    chk_rd("R5", mk(58'h11, 4), 1'b1, 64'hB);
    do_wr(mk(58'h12, 4), 64'hD);  // third way still free if no duplicate
    chk_rd("R5", mk(58'h10, 4), 1'b1, 64'hC);
    chk_rd("R5", mk(58'h11, 4), 1'b1, 64'hB);
  endtask

  task automatic t_hash_R6;
    do_wr(mk(58'h1, 3), 64'hAAA);
    chk_rd("R6", mk(58'h2000, 3), 1'b1, 64'hAAA);     // slice1=1 folds to 1
    chk_rd("R6", mk(58'h1 << 52, 3), 1'b1, 64'hAAA);  // last slice bit 0
    chk_rd("R6", mk(58'h2, 3), 1'b0, '0);
    chk_rd("R6", mk(58'h1, 8), 1'b0, '0);
  endtask

  task automatic t_fill_evict_R7_R8;
    // set 5: ways 0,1,2 filled in order, used bits end as {way2}
    do_wr(mk(58'h21, 5), 64'h21);
    do_wr(mk(58'h22, 5), 64'h22);
    do_wr(mk(58'h23, 5), 64'h23);
    chk_rd("R7", mk(58'h21, 5), 1'b1, 64'h21);
    chk_rd("R7", mk(58'h23, 5), 1'b1, 64'h23);
    do_wr(mk(58'h24, 5), 64'h24);  // evicts way0 (0x21); used={0,2}
    chk_rd("R8", mk(58'h21, 5), 1'b0, '0);
    chk_rd("R8", mk(58'h22, 5), 1'b1, 64'h22);
    do_wr(mk(58'h22, 5), 64'h122); // hit way1 -> all used -> used={1}
    do_wr(mk(58'h25, 5), 64'h25);  // victim way0 (0x24)
    chk_rd("R8", mk(58'h24, 5), 1'b0, '0);
    chk_rd("R8", mk(58'h23, 5), 1'b1, 64'h23);
    chk_rd("R8", mk(58'h25, 5), 1'b1, 64'h25);
    chk_rd("R8", mk(58'h22, 5), 1'b1, 64'h122);
  endtask

  task automatic t_reads_passive_R10;
    do_wr(mk(58'h31, 7), 64'h31);
    do_wr(mk(58'h32, 7), 64'h32);
    do_wr(mk(58'h33, 7), 64'h33);
    for (int i = 0; i < 3; i++) chk_rd("R10", mk(58'h31, 7), 1'b1, 64'h31);
    do_wr(mk(58'h34, 7), 64'h34);  // way0 still victim despite reads
    chk_rd("R10", mk(58'h31, 7), 1'b0, '0);
    chk_rd("R10", mk(58'h32, 7), 1'b1, 64'h32);
  endtask

  task automatic t_same_cycle_R9;
    do_wr(mk(58'h41, 11), 64'h100);
    @(negedge clk_i);
    rd_en_i = 1'b1; rd_pc_i = mk(58'h41, 11);
    wr_en_i = 1'b1; wr_pc_i = mk(58'h41, 11); wr_value_i = 64'h200;
    @(negedge clk_i);
    rd_en_i = 1'b0; wr_en_i = 1'b0;
    check("R9", rd_hit_o, rd_value_o, 1'b1, 64'h100);
    chk_rd("R9", mk(58'h41, 11), 1'b1, 64'h200);
    @(negedge clk_i);
    rd_en_i = 1'b1; rd_pc_i = mk(58'h42, 12);
    wr_en_i = 1'b1; wr_pc_i = mk(58'h42, 12); wr_value_i = 64'h300;
    @(negedge clk_i);
    rd_en_i = 1'b0; wr_en_i = 1'b0;
    check("R9", rd_hit_o, rd_value_o, 1'b0, '0);
    chk_rd("R9", mk(58'h42, 12), 1'b1, 64'h300);
  endtask

  initial begin
    #(8 * 200000);
    total++;
    $display("FAIL watchdog: hit=0 value=0 expected hit=1 value=1");
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset_R1();
    t_basic_R3_R4_R2();
    t_overwrite_R5();
    t_hash_R6();
    t_fill_evict_R7_R8();
    t_reads_passive_R10();
    t_same_cycle_R9();
    $display("%0d/%0d checks passed", passed, total);
    $finish;
  end
endmodule